// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every request that can restart the digital core into one synchronous system reset, and keeps a record of which request caused it. Five sources are served: an active-low external reset pin, expiry pulses from two separate watchdogs, a software reset-request bit and a low-power management request. The pin is synchronized before use. Once any source is active, the system reset output is held for a fixed minimum number of clock cycles, and it is held again from the start each time a source shows up.

Three reset domains are kept apart. The power-on reset (`rst_ni`) clears the whole block, asserts the system reset and sets its own flag. The system reset leaves the source flags and the backup domain alone. The backup-domain reset is a separate output that follows only its own request and a software bit. Software reads the sticky flags to learn why the core restarted, and clears them with a single write.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1, `bkp_rst_o` is 0 and `status_o` is 6'b000010 (only the power flag, bit 1, is set).
- R2: After `rst_ni` is released, `sys_rst_o` stays 1 for exactly HOLD_CYCLES (default 20) clock edges and then falls to 0.
- R3: A low level on `ext_rst_ni` passes through a 2-stage synchronizer. If the pin is low at edge k, `sys_rst_o` becomes 1 and `status_o[0]` becomes 1 after edge k+2.
- R4: A high level on `wwdg_expire_i` or `iwdg_expire_i` at an edge sets `sys_rst_o` to 1 after that edge. It also sets `status_o[4]` (window watchdog) or `status_o[3]` (independent watchdog).
- R5: A high level on `sw_rst_req_i` at an edge sets `sys_rst_o` to 1 and sets `status_o[2]`.
- R6: A high level on `lp_rst_req_i` at an edge sets `sys_rst_o` to 1 and sets `status_o[5]`.
- R7: `sys_rst_o` stays 1 for HOLD_CYCLES edges after the last edge at which any source was active. A new source restarts the full hold period.
- R8: Flags are sticky. A set flag stays set until `rst_ni` or `flag_clr_i`, and it survives the system reset it caused.
- R9: When `flag_clr_i` is high at an edge, all flags clear at that edge. The exception is a source that is active at the same edge: its flag is set.
- R10: `bkp_rst_o` equals `bkp_rst_req_i | sw_bkp_rst_i` as sampled at the previous edge.
- R11: No system reset source drives `bkp_rst_o`. The backup reset inputs have no effect on `sys_rst_o` or `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| wwdg_expire_i | input | 1 | Window watchdog end of count |
| iwdg_expire_i | input | 1 | Independent watchdog end of count |
| sw_rst_req_i | input | 1 | Software system reset request |
| lp_rst_req_i | input | 1 | Low-power management reset request |
| flag_clr_i | input | 1 | Software write that removes all flags |
| bkp_rst_req_i | input | 1 | Backup-domain reset request |
| sw_bkp_rst_i | input | 1 | Software backup-domain reset bit |
| sys_rst_o | output | 1 | System reset, active high, synchronous |
| bkp_rst_o | output | 1 | Backup-domain reset, active high |
| status_o | output | 6 | Sticky flags: [0] pin, [1] power, [2] software, [3] independent watchdog, [4] window watchdog, [5] low power |

## Verification
Each source is pulsed on its own, so every flag bit is shown to map to exactly one input. A low pin is held across several edges to expose the two-cycle synchronizer delay. A second watchdog pulse in the middle of a hold period tells a restarting stretch apart from a one-shot one. A clear arriving in the same cycle as an event separates set-wins ordering from clear-wins ordering. A power reset in the middle of the run shows that only that reset brings the flags back to the power-only state.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_PIN  = 0;
  localparam int SRC_POR  = 1;
  localparam int SRC_SW   = 2;
  localparam int SRC_IWDG = 3;
  localparam int SRC_WWDG = 4;
  localparam int SRC_LP   = 5;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[i] <= RST_VAL;
      else if (i == 0) chain_q[i] <= d_i;
      else             chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  // power reset loads the full hold so the core sees reset after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= HOLD_V;
    else if (trig_i)        cnt_q <= HOLD_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rst_flags.sv
module rst_flags #(
  parameter int N       = 6,
  parameter int POR_IDX = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    localparam logic RV = (i == POR_IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[i] <= RV;
      else         flags_q[i] <= (flags_q[i] & ~clr_i) | set_i[i];
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int HOLD_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_rst_ni,
  input  logic            wwdg_expire_i,
  input  logic            iwdg_expire_i,
  input  logic            sw_rst_req_i,
  input  logic            lp_rst_req_i,
  input  logic            flag_clr_i,
  input  logic            bkp_rst_req_i,
  input  logic            sw_bkp_rst_i,
  output logic            sys_rst_o,
  output logic            bkp_rst_o,
  output logic [NSRC-1:0] status_o
);
  logic            pin_s;
  logic            pin_evt;
  logic [NSRC-1:0] evt;
  logic            any_evt;
  logic            bkp_q;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_s)
  );

  assign pin_evt = ~pin_s;

  always_comb begin
    evt           = '0;
    evt[SRC_PIN]  = pin_evt;
    evt[SRC_SW]   = sw_rst_req_i;
    evt[SRC_IWDG] = iwdg_expire_i;
    evt[SRC_WWDG] = wwdg_expire_i;
    evt[SRC_LP]   = lp_rst_req_i;
  end

  assign any_evt = |evt;

  rst_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (any_evt),
    .active_o(sys_rst_o)
  );

  rst_flags #(.N(NSRC), .POR_IDX(SRC_POR)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (flag_clr_i),
    .flags_o(status_o)
  );

  // backup domain: own request or software bit only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bkp_q <= 1'b0;
    else         bkp_q <= bkp_rst_req_i | sw_bkp_rst_i;
  end

  assign bkp_rst_o = bkp_q;
endmodule

// File: rtl/sys_reset_ctrl_chk.sv
module sys_reset_ctrl_chk #(
  parameter int HOLD = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wwdg_expire_i,
  input logic       iwdg_expire_i,
  input logic       sw_rst_req_i,
  input logic       lp_rst_req_i,
  input logic       flag_clr_i,
  input logic       bkp_rst_req_i,
  input logic       sw_bkp_rst_i,
  input logic       pin_evt,
  input logic       sys_rst_o,
  input logic       bkp_rst_o,
  input logic [5:0] status_o
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= 0;
    else if (sys_rst_o) run_len <= (run_len < 32'hFFFF) ? run_len + 1 : run_len;
    else                run_len <= 0;
  end

  // R3
  pin_to_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_evt |=> (sys_rst_o && status_o[0]));

  // R4
  wdog_to_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wwdg_expire_i || iwdg_expire_i) |=> sys_rst_o);

  // R5
  sw_to_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_i |=> (sys_rst_o && status_o[2]));

  // R6
  lp_to_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_rst_req_i |=> (sys_rst_o && status_o[5]));

  // R7
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (run_len >= HOLD));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R9
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !wwdg_expire_i && !iwdg_expire_i && !sw_rst_req_i && !lp_rst_req_i)
      |=> (status_o[5:1] == 5'b0));

  // R11
  bkp_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bkp_rst_req_i && !sw_bkp_rst_i) |=> !bkp_rst_o);
endmodule

bind sys_reset_ctrl sys_reset_ctrl_chk #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wwdg_expire_i(wwdg_expire_i),
  .iwdg_expire_i(iwdg_expire_i),
  .sw_rst_req_i (sw_rst_req_i),
  .lp_rst_req_i (lp_rst_req_i),
  .flag_clr_i   (flag_clr_i),
  .bkp_rst_req_i(bkp_rst_req_i),
  .sw_bkp_rst_i (sw_bkp_rst_i),
  .pin_evt      (pin_evt),
  .sys_rst_o    (sys_rst_o),
  .bkp_rst_o    (bkp_rst_o),
  .status_o     (status_o)
);

// File: tb/sim_sys_reset_ctrl.sv
module sim_sys_reset_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_n = 1'b1;
  logic wwdg = 1'b0, iwdg = 1'b0, swr = 1'b0, lpr = 1'b0;
  logic clr = 1'b0, bkp_req = 1'b0, sw_bkp = 1'b0;
  logic sys_rst, bkp_rst;
  logic [5:0] status;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  sys_reset_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n),
    .wwdg_expire_i(wwdg), .iwdg_expire_i(iwdg), .sw_rst_req_i(swr),
    .lp_rst_req_i(lpr), .flag_clr_i(clr), .bkp_rst_req_i(bkp_req),
    .sw_bkp_rst_i(sw_bkp), .sys_rst_o(sys_rst), .bkp_rst_o(bkp_rst),
    .status_o(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int   m_cnt;
  logic [5:0] m_flags;
  logic m_bkp;
  logic pin_q[$];

  always @(posedge clk or negedge rst_n) begin
    logic [5:0] ev;
    if (!rst_n) begin
      m_cnt = HOLD; m_flags = 6'b000010; m_bkp = 1'b0; pin_q.delete();
    end else begin
      ev = '0;
      if (pin_q.size() >= 2 && pin_q[pin_q.size()-2] == 1'b0) ev[0] = 1'b1;
      ev[2] = swr; ev[3] = iwdg; ev[4] = wwdg; ev[5] = lpr;
      pin_q.push_back(ext_n);
      if (pin_q.size() > 2) void'(pin_q.pop_front());
      if (ev != 0) m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (clr) m_flags = '0;
      m_flags = m_flags | ev;
      m_bkp = bkp_req | sw_bkp;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({cur_req, " sys_rst_o"}, int'(sys_rst), int'(m_cnt > 0));
    chk({cur_req, " status_o"}, int'(status), int'(m_flags));
    chk({cur_req, " bkp_rst_o"}, int'(bkp_rst), int'(m_bkp));
  endtask

  task automatic ticks_until_low(output int n);
    n = 0;
    while (sys_rst && n < 200) begin tick(); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int n;
    // R1 reset state
    cur_req = "R1";
    repeat (3) tick();
    chk("R1 sys", int'(sys_rst), 1);
    chk("R1 status", int'(status), 2);
    chk("R1 bkp", int'(bkp_rst), 0);
    rst_n = 1'b1;
    // R2 hold after power release
    cur_req = "R2";
    ticks_until_low(n);
    chk("R2 hold length", n, HOLD);
    // R9 clear
    cur_req = "R9";
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R9 cleared", int'(status), 0);
    // R4 window watchdog
    cur_req = "R4";
    wwdg = 1'b1; tick(); wwdg = 1'b0;
    chk("R4 sys after wwdg", int'(sys_rst), 1);
    chk("R4 wwdg flag", int'(status), 16);
    ticks_until_low(n);
    chk("R4 hold length", n, HOLD);
    iwdg = 1'b1; tick(); iwdg = 1'b0;
    chk("R4 iwdg flag", int'(status), 24);
    ticks_until_low(n);
    // R5 software
    cur_req = "R5";
    swr = 1'b1; tick(); swr = 1'b0;
    chk("R5 sys", int'(sys_rst), 1);
    chk("R5 flag", int'(status), 28);
    ticks_until_low(n);
    // R6 low power
    cur_req = "R6";
    lpr = 1'b1; tick(); lpr = 1'b0;
    chk("R6 sys", int'(sys_rst), 1);
    chk("R6 flag", int'(status), 60);
    ticks_until_low(n);
    clr = 1'b1; tick(); clr = 1'b0;
    // R3 pin through synchronizer
    cur_req = "R3";
    ext_n = 1'b0;
    tick(); chk("R3 after edge k", int'(sys_rst), 0);
    tick(); chk("R3 after edge k+1", int'(sys_rst), 0);
    tick(); chk("R3 after edge k+2", int'(sys_rst), 1);
    chk("R3 pin flag", int'(status), 1);
    ext_n = 1'b1;
    ticks_until_low(n);
    clr = 1'b1; tick(); clr = 1'b0;
    // R7 retrigger
    cur_req = "R7";
    wwdg = 1'b1; tick(); wwdg = 1'b0;
    repeat (10) tick();
    wwdg = 1'b1; tick(); wwdg = 1'b0;
    ticks_until_low(n);
    chk("R7 restarted hold", n, HOLD);
    // R9 clear with simultaneous event
    cur_req = "R9";
    clr = 1'b1; iwdg = 1'b1; tick(); clr = 1'b0; iwdg = 1'b0;
    chk("R9 set wins", int'(status), 8);
    // R8 sticky across system reset
    cur_req = "R8";
    ticks_until_low(n);
    repeat (3) tick();
    chk("R8 flag kept", int'(status), 8);
    // R10 backup reset
    cur_req = "R10";
    bkp_req = 1'b1; tick(); bkp_req = 1'b0;
    chk("R10 bkp from req", int'(bkp_rst), 1);
    tick();
    chk("R10 bkp released", int'(bkp_rst), 0);
    sw_bkp = 1'b1;
    repeat (3) tick();
    chk("R10 bkp from sw bit", int'(bkp_rst), 1);
    // R11 isolation
    cur_req = "R11";
    chk("R11 sys untouched", int'(sys_rst), 0);
    chk("R11 flags untouched", int'(status), 8);
    sw_bkp = 1'b0;
    tick();
    wwdg = 1'b1; tick(); wwdg = 1'b0;
    chk("R11 bkp not from sys", int'(bkp_rst), 0);
    repeat (5) tick();
    // R1 power reset mid-run
    cur_req = "R1";
    rst_n = 1'b0; tick();
    chk("R1 flags after por", int'(status), 2);
    chk("R1 sys during por", int'(sys_rst), 1);
    rst_n = 1'b1;
    cur_req = "R2";
    ticks_until_low(n);
    chk("R2 hold after second por", n, HOLD);
    finish_run();
  end
endmodule